// File: doc/BRIEF.md
# Stall-Driven Operating Point Controller

This controller picks the clock divisor and supply code for one tile's core. The core trades data with the interconnect through single-entry boundary buffers, one for each stream. Every cycle, the core-side ports report two things: whether a read found its input buffer empty, and whether a write found its output buffer full. A starved input means the core cannot keep up, so it must run faster. A full output means the core is producing more than the network takes, so it can slow down.

Stall events of each kind are counted over a window whose length is programmable. At the end of each window the controller compares both counts with a programmable limit. It then moves the operating point by at most one step of four: divide by 1, 2, 4 or 8. Each step has a fixed supply code. The voltage and the clock never change in the same cycle. When speeding up, the supply rises first. When slowing down, the clock slows first. A fixed settle interval separates the two moves.

Top module: `dvfs_port_ctrl`

## Requirements
- R1: After reset, both div_sel and vsel are 0 (full speed, highest supply).
- R2: A window lasts win_cycles clock cycles (0 is treated as 1), and the first window starts with the first cycle after reset. Outputs change only after a window end or during a pending settle.
- R3: At a window end, if the number of in_stall cycles in the window is greater than stall_limit and the out_stall count is not, the operating point moves one step faster (div_sel decreases by 1).
- R4: At a window end, if the out_stall count is greater than stall_limit and the in_stall count is not, the operating point moves one step slower (div_sel increases by 1).
- R5: If both counts exceed stall_limit, or neither does, the operating point is held. A count equal to the limit does not exceed it.
- R6: On a speed-up decided at clock edge E, vsel takes the new code at E and div_sel takes it at E+SETTLE. vsel is never greater than div_sel. The vsel codes 0, 1, 2 and 3 mean 1.8 V, 1.16 V, 0.73 V and 0.6 V.
- R7: On a slow-down decided at edge E, div_sel takes the new code at E and vsel takes it at E+SETTLE. A div_sel code k selects a clock divided by 2 to the power k.
- R8: A window that calls for a speed-up at code 0, or for a slow-down at code 3, leaves the outputs unchanged.
- R9: A window end that falls while a settle is pending, including the edge on which the settle completes, makes no change. Its counts are still cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_stall | input | 1 | A core read found its input buffer empty this cycle |
| out_stall | input | 1 | A core write found its output buffer full this cycle |
| win_cycles | input | WIN_W | Window length in cycles |
| stall_limit | input | CNT_W | Count that must be exceeded to act |
| div_sel | output | 2 | Clock divisor code (divide by 2^code) |
| vsel | output | 2 | Supply level code, 0 is highest |

## Verification
The first move of an operating-point change appears on the edge that closes the window. That edge is the one that samples the window's last stall input. The second move lands exactly SETTLE edges later. The reference model in the bench advances on the same edges and is compared with both outputs at each falling edge, so every register delay shows up as a mismatch in a specific cycle. The directed checks sample one time unit after the closing edge of each window to see the first step, and one full window later to see the second.

// File: rtl/dvfs_port_ctrl.sv
module dvfs_port_ctrl #(
  parameter int WIN_W  = 16,
  parameter int CNT_W  = 12,
  parameter int SETTLE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_stall,
  input  logic             out_stall,
  input  logic [WIN_W-1:0] win_cycles,
  input  logic [CNT_W-1:0] stall_limit,
  output logic [1:0]       div_sel,
  output logic [1:0]       vsel
);
  localparam int SC_W = (SETTLE < 2) ? 1 : $clog2(SETTLE);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [SC_W-1:0] SC_LOAD = SC_W'(SETTLE - 1);

  logic [WIN_W-1:0] pos, last;
  logic [CNT_W-1:0] n_in, n_out, in_nx, out_nx;
  logic             busy;
  logic [SC_W-1:0]  sc;
  logic [1:0]       tgt;
  logic             win_end, starve, clog, go_up, go_dn;

  assign last    = (win_cycles == '0) ? '0 : win_cycles - 1'b1;
  assign win_end = pos >= last;
  assign in_nx   = (in_stall  && n_in  != CMAX) ? n_in  + 1'b1 : n_in;
  assign out_nx  = (out_stall && n_out != CMAX) ? n_out + 1'b1 : n_out;
  assign starve  = in_nx  > stall_limit;
  assign clog    = out_nx > stall_limit;
  assign go_up   = win_end && !busy && starve && !clog && div_sel != 2'd0;
  assign go_dn   = win_end && !busy && clog && !starve && div_sel != 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      n_in  <= '0;
      n_out <= '0;
    end else if (win_end) begin
      pos   <= '0;
      n_in  <= '0;
      n_out <= '0;
    end else begin
      pos   <= pos + 1'b1;
      n_in  <= in_nx;
      n_out <= out_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sel <= 2'd0;
      vsel    <= 2'd0;
      tgt     <= 2'd0;
      busy    <= 1'b0;
      sc      <= '0;
    end else if (busy) begin
      if (sc == '0) begin
        div_sel <= tgt;
        vsel    <= tgt;
        busy    <= 1'b0;
      end else begin
        sc <= sc - 1'b1;
      end
    end else if (go_up) begin
      vsel <= div_sel - 2'd1;
      tgt  <= div_sel - 2'd1;
      busy <= 1'b1;
      sc   <= SC_LOAD;
    end else if (go_dn) begin
      div_sel <= div_sel + 2'd1;
      tgt     <= div_sel + 2'd1;
      busy    <= 1'b1;
      sc      <= SC_LOAD;
    end
  end

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_sel) |-> ({1'b0, div_sel} == {1'b0, $past(div_sel)} + 3'd1) ||
                          ({1'b0, div_sel} + 3'd1 == {1'b0, $past(div_sel)})); // R3
  AST_QUIET_MID_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_sel) |-> $past(win_end) || $past(busy)); // R2
  AST_SUPPLY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel < $past(div_sel)) |-> $past(vsel) == div_sel); // R6
  AST_CLOCK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (vsel > $past(vsel)) |-> $past(div_sel) == vsel); // R7
  AST_SUPPLY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    vsel <= div_sel); // R6
  AST_IDLE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> vsel == div_sel); // R9
endmodule

// File: tb/dvfs_port_ctrl_tb.sv
module dvfs_port_ctrl_tb;
  localparam int PER    = 10;
  localparam int SETTLE = 4;
  localparam int WIN_W  = 16;
  localparam int CNT_W  = 12;

  logic clk = 0, rst_n = 0, in_stall = 0, out_stall = 0;
  logic [WIN_W-1:0] win_cycles = 16'd8;
  logic [CNT_W-1:0] stall_limit = 12'd3;
  logic [1:0] div_sel, vsel;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  dvfs_port_ctrl #(.WIN_W(WIN_W), .CNT_W(CNT_W), .SETTLE(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_stall(in_stall), .out_stall(out_stall),
    .win_cycles(win_cycles), .stall_limit(stall_limit),
    .div_sel(div_sel), .vsel(vsel));

  int m_pos, m_in, m_out, m_div, m_v, m_goal, m_due, cyc;
  bit m_pend;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_in = 0; m_out = 0; m_div = 0; m_v = 0; m_pend = 0; cyc = 0;
    end else begin
      int len, ni, no;
      bit closing;
      cyc++;
      len = (win_cycles == 0) ? 1 : int'(win_cycles);
      ni = m_in + (in_stall ? 1 : 0);
      no = m_out + (out_stall ? 1 : 0);
      closing = (m_pos + 1 >= len);
      if (m_pend && cyc == m_due) begin
        m_div = m_goal; m_v = m_goal; m_pend = 0;
      end else if (closing && !m_pend) begin
        if (ni > int'(stall_limit) && no <= int'(stall_limit) && m_div > 0) begin
          m_goal = m_div - 1; m_v = m_goal; m_pend = 1; m_due = cyc + SETTLE;
        end else if (no > int'(stall_limit) && ni <= int'(stall_limit) && m_div < 3) begin
          m_goal = m_div + 1; m_div = m_goal; m_pend = 1; m_due = cyc + SETTLE;
        end
      end
      if (closing) begin m_pos = 0; m_in = 0; m_out = 0; end
      else begin m_pos++; m_in = ni; m_out = no; end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    tests++;
    if (div_sel != 2'(m_div) || vsel != 2'(m_v)) begin
      fails++;
      $display("FAIL R2 per-cycle cyc %0d: div=%0d vsel=%0d expected div=%0d vsel=%0d",
               cyc, div_sel, vsel, m_div, m_v);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_window(input int nin, input int nout);
    for (int i = 0; i < int'(win_cycles); i++) begin
      @(negedge clk);
      in_stall  = (i < nin);
      out_stall = (i < nout);
    end
    @(posedge clk); #1;
    in_stall = 0; out_stall = 0;
  endtask

  initial begin
    #(PER*100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(PER*3);
    chk("R1 div after reset", div_sel, 0);
    chk("R1 vsel after reset", vsel, 0);
    @(posedge clk); #1 rst_n = 1;

    run_window(8, 0);
    chk("R8 speed-up at top div", div_sel, 0);
    chk("R8 speed-up at top vsel", vsel, 0);

    run_window(0, 5);
    chk("R4 slow-down div first", div_sel, 1);
    chk("R7 supply held during settle", vsel, 0);
    run_window(0, 0);
    chk("R7 supply lowered after settle", vsel, 1);

    run_window(0, 3);
    chk("R5 count equal to limit holds", div_sel, 1);
    run_window(6, 6);
    chk("R5 both over limit holds div", div_sel, 1);
    chk("R5 both over limit holds vsel", vsel, 1);

    run_window(0, 8); run_window(0, 0);
    run_window(0, 8); run_window(0, 0);
    chk("R4 reached slowest div", div_sel, 3);
    chk("R4 reached slowest vsel", vsel, 3);
    run_window(0, 8);
    chk("R8 slow-down at bottom", div_sel, 3);

    run_window(4, 0);
    chk("R6 supply raised first", vsel, 2);
    chk("R6 clock held during settle", div_sel, 3);
    run_window(0, 0);
    chk("R6 clock raised after settle", div_sel, 2);

    run_window(4, 2);
    run_window(0, 0);
    chk("R3 speed-up with low out count", div_sel, 1);
    chk("R3 speed-up vsel", vsel, 1);

    win_cycles = 16'd2; stall_limit = 12'd0;
    run_window(0, 1);
    chk("R7 short window first step", div_sel, 2);
    run_window(0, 1);
    chk("R9 window during settle ignored", div_sel, 2);
    run_window(0, 1);
    chk("R9 settle-completion window ignored div", div_sel, 2);
    chk("R9 settle completes vsel", vsel, 2);
    run_window(0, 1);
    chk("R9 next window acts", div_sel, 3);

    repeat (10) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule